// File: doc/BRIEF.md
# Instruction Prefetch Queue with Redirect Flush

This block runs ahead of a decode stage and fetches fixed-width 32-bit instructions into a small on-chip queue. The next instruction is therefore already held in a register when decode asks for it. It issues word-aligned addresses that rise by four to an instruction memory over a valid/ready request channel. It takes responses back in issue order and hands each queued instruction, together with its address, to decode over a valid/ready output channel.

A redirect pulse carries a new target, for example after a taken branch or jump. That pulse discards everything queued and still in flight, and fetching restarts at the target with its two low bits cleared. Every request carries a small epoch tag, and the memory returns that tag with its response. A response whose tag no longer matches the current epoch belongs to the old path and is thrown away. New requests are issued only while queued plus outstanding fetches of the current epoch stay below the queue depth, so the response channel needs no ready signal and no response can be lost.

Back-pressure rules: a request is taken when `mreq_valid && mreq_ready`. While it waits, its address and tag do not change, unless a redirect withdraws it. The output transfers on `out_valid && out_ready`. While decode stalls, the presented instruction is held until it is taken or a redirect flushes it.

Top module: `ifetch_queue`

## Requirements
- R1: After reset the output valid is low, and the first request presented is valid with address 0 and epoch tag 0.
- R2: Each accepted request is followed by one at the previous address plus 4. A request left waiting by `mreq_ready` low keeps the same address on the next cycle unless a redirect occurs.
- R3: Instructions leave in request order. Each `out_pc` equals the address that was fetched, and `out_instr` equals the memory word returned for that address.
- R4: Queued plus outstanding current-epoch fetches never exceed DEPTH (8). `mreq_valid` is high exactly when that total is below DEPTH and no redirect is present.
- R5: In a cycle with `redir_valid` high, `out_valid` and `mreq_valid` are low. The next request address is `redir_addr` with bits [1:0] forced to 0.
- R6: Responses whose epoch tag differs from the current one are discarded. After a redirect, the first instruction delivered is the one at the aligned target.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle presents the same `out_pc` and `out_instr` with `out_valid` still high, unless a redirect occurs.
- R8: Once the queue holds DEPTH instructions, DEPTH consecutive cycles with `out_ready` high each deliver an instruction with no gap.
- R9: The epoch tag on `mreq_epoch` advances by one (modulo 2^EPOCH_W) in the cycle after each redirect and is otherwise constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Flush and restart at `redir_addr` |
| redir_addr | input | AW | New fetch target; low two bits ignored |
| mreq_valid | output | 1 | Fetch request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | AW | Word-aligned fetch address |
| mreq_epoch | output | EPOCH_W | Tag the memory echoes with the response |
| mrsp_valid | input | 1 | Response word present (always taken) |
| mrsp_data | input | IW | Fetched instruction word |
| mrsp_epoch | input | EPOCH_W | Tag of the request this response answers |
| out_valid | output | 1 | Instruction available to decode |
| out_ready | input | 1 | Decode takes the instruction |
| out_pc | output | AW | Address of the presented instruction |
| out_instr | output | IW | Presented instruction word |

## Verification
Some internal faults show up as soon as decode consumes. A wrong read pointer, a missed flush or a mismatched epoch compare all produce an `out_pc`/`out_instr` pair that differs from the next address the scoreboard expects, on the very transfer where the stale or misplaced word leaves. A credit count that drifts shows up at the request port within a cycle: `mreq_valid` rises while the scoreboard already holds DEPTH entries, or stays low with room left. A bad address step is caught on the next accepted request. The directed fill-then-drain sequence exposes any extra register stage between the queue head and the output, as a gap in `out_valid`.

// File: rtl/fq_pkg.sv
package fq_pkg;
  // bytes between consecutive fixed-width instructions
  localparam int unsigned STEP_BYTES = 4;
  // low address bits that are always zero for an instruction
  localparam int unsigned ALIGN_BITS = 2;
endpackage

// File: rtl/fq_addr_gen.sv
module fq_addr_gen
  import fq_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned EPOCH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               redir_valid,
  input  logic [AW-1:0]      redir_addr,
  input  logic               req_fire,
  input  logic               rsp_take,
  output logic [AW-1:0]      fetch_pc,
  output logic [AW-1:0]      rsp_pc,
  output logic [EPOCH_W-1:0] epoch
);
  localparam logic [AW-1:0] STEP       = AW'(STEP_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = AW'((1 << ALIGN_BITS) - 1);

  logic [AW-1:0] target;
  assign target = redir_addr & ~ALIGN_MASK;

  // request side address and epoch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc <= '0;
      epoch    <= '0;
    end else if (redir_valid) begin
      fetch_pc <= target;
      epoch    <= epoch + 1'b1;
    end else if (req_fire) begin
      fetch_pc <= fetch_pc + STEP;
    end
  end

  // address of the next response that will be queued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rsp_pc <= '0;
    else if (redir_valid) rsp_pc <= target;
    else if (rsp_take)    rsp_pc <= rsp_pc + STEP;
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !redir_valid |=> fetch_pc == $past(fetch_pc) + STEP);
  // R5
  redir_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> fetch_pc[ALIGN_BITS-1:0] == '0 &&
                    fetch_pc[AW-1:ALIGN_BITS] == $past(redir_addr[AW-1:ALIGN_BITS]));
  // R9
  epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> epoch == $past(epoch) + 1'b1);
  // R9
  epoch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |=> $stable(epoch));
endmodule

// File: rtl/fq_credit.sv
module fq_credit #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_fire,
  input  logic          rsp_take,
  input  logic [CW-1:0] q_count,
  output logic          can_issue
);
  logic [CW-1:0] outstanding;
  logic [CW:0]   committed;

  assign committed = {1'b0, q_count} + {1'b0, outstanding};
  assign can_issue = committed < (CW+1)'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      outstanding <= '0;
    else if (flush)  outstanding <= '0;
    else begin
      case ({req_fire, rsp_take})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  // R4
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    committed <= (CW+1)'(DEPTH));
  // R4
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> outstanding != '0);
endmodule

// File: rtl/fq_fifo.sv
module fq_fifo #(
  parameter  int unsigned W     = 64,
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) slots[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);
  assign rdata = slots[rd_ptr];

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> count < CW'(DEPTH) || pop);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue #(
  parameter int unsigned AW      = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned EPOCH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               redir_valid,
  input  logic [AW-1:0]      redir_addr,
  output logic               mreq_valid,
  input  logic               mreq_ready,
  output logic [AW-1:0]      mreq_addr,
  output logic [EPOCH_W-1:0] mreq_epoch,
  input  logic               mrsp_valid,
  input  logic [IW-1:0]      mrsp_data,
  input  logic [EPOCH_W-1:0] mrsp_epoch,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [AW-1:0]      out_pc,
  output logic [IW-1:0]      out_instr
);
  localparam int unsigned EW = AW + IW;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic               req_fire, rsp_take, out_fire, can_issue, q_empty;
  logic [AW-1:0]      fetch_pc, rsp_pc;
  logic [EPOCH_W-1:0] epoch;
  logic [CW-1:0]      q_count;
  logic [EW-1:0]      q_head;

  assign mreq_valid = can_issue && !redir_valid;
  assign mreq_addr  = fetch_pc;
  assign mreq_epoch = epoch;
  assign req_fire   = mreq_valid && mreq_ready;
  assign rsp_take   = mrsp_valid && (mrsp_epoch == epoch) && !redir_valid;
  assign out_valid  = !q_empty && !redir_valid;
  assign out_fire   = out_valid && out_ready;
  assign out_pc     = q_head[IW +: AW];
  assign out_instr  = q_head[IW-1:0];

  fq_addr_gen #(.AW(AW), .EPOCH_W(EPOCH_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .req_fire(req_fire), .rsp_take(rsp_take),
    .fetch_pc(fetch_pc), .rsp_pc(rsp_pc), .epoch(epoch)
  );

  fq_credit #(.DEPTH(DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid), .req_fire(req_fire),
    .rsp_take(rsp_take), .q_count(q_count), .can_issue(can_issue)
  );

  fq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid), .push(rsp_take),
    .wdata({rsp_pc, mrsp_data}), .pop(out_fire),
    .rdata(q_head), .empty(q_empty), .count(q_count)
  );

  // R5
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !out_valid && !mreq_valid);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> redir_valid ||
      (out_valid && $stable(out_pc) && $stable(out_instr)));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> redir_valid || (mreq_valid && $stable(mreq_addr)));
  // R6
  stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_valid && (mrsp_epoch != mreq_epoch) && !out_fire && !redir_valid
      |=> q_count == $past(q_count));
endmodule

// File: tb/sim_ifetch_queue.sv
module sim_ifetch_queue;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_addr = '0;
  logic        mreq_valid, mreq_ready = 1'b0;
  logic [31:0] mreq_addr;
  logic [1:0]  mreq_epoch;
  logic        mrsp_valid = 1'b0;
  logic [31:0] mrsp_data = '0;
  logic [1:0]  mrsp_epoch = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_pc, out_instr;

  always #5 clk = ~clk;

  ifetch_queue u0 (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_epoch(mreq_epoch), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .mrsp_epoch(mrsp_epoch), .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_instr(out_instr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // memory model (in order) and scoreboard
  logic [31:0] pq_addr[$];
  logic [1:0]  pq_ep[$];
  int          pq_due[$];
  int          last_due = 0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_pc = '0;
  logic [1:0]  ep = '0;
  bit          prev_hold = 0;
  logic [31:0] prev_pc, prev_instr;
  bit          await_first = 0;
  logic [31:0] first_target;
  int          since_redir = 100;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC3A5_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit rd, input logic [31:0] ra, input int rdy_pct,
                      input int ordy_pct, input int lat_max, input bit b2b);
    bit mfire, ofire;
    logic [31:0] e;
    int due;
    @(negedge clk);
    cyc++;
    redir_valid = rd;
    redir_addr  = ra;
    mreq_ready  = ($urandom_range(99) < rdy_pct);
    out_ready   = ($urandom_range(99) < ordy_pct);
    if (pq_due.size() > 0 && pq_due[0] <= cyc) begin
      mrsp_valid = 1'b1;
      mrsp_data  = word_at(pq_addr[0]);
      mrsp_epoch = pq_ep[0];
      void'(pq_addr.pop_front()); void'(pq_ep.pop_front()); void'(pq_due.pop_front());
    end else begin
      mrsp_valid = 1'b0;
    end
    #1;
    // R5: quiet outputs during a redirect
    if (rd) begin
      check(!out_valid, "R5", "out_valid during redirect", 32'(out_valid), 0);
      check(!mreq_valid, "R5", "mreq_valid during redirect", 32'(mreq_valid), 0);
    end
    // R9: epoch tag
    check(mreq_epoch == ep, "R9", "mreq_epoch", 32'(mreq_epoch), 32'(ep));
    // R4: credit bound and eager issue
    check(exp_q.size() <= DEPTH, "R4", "committed fetches", exp_q.size(), DEPTH);
    if (!rd)
      check(mreq_valid == (exp_q.size() < DEPTH), "R4", "mreq_valid vs room",
            32'(mreq_valid), 32'(exp_q.size() < DEPTH));
    // R7: held output
    if (prev_hold && !rd) begin
      check(out_valid && out_pc == prev_pc, "R7", "held out_pc", out_pc, prev_pc);
      check(out_instr == prev_instr, "R7", "held out_instr", out_instr, prev_instr);
    end
    // R8: no gap while draining a full queue
    if (b2b) check(out_valid, "R8", "back-to-back out_valid", 32'(out_valid), 1);
    // R2: request address
    mfire = mreq_valid && mreq_ready;
    if (mreq_valid && !rd)
      check(mreq_addr == exp_pc, "R2", "mreq_addr", mreq_addr, exp_pc);
    if (mfire) begin
      exp_q.push_back(mreq_addr);
      due = cyc + $urandom_range(lat_max, 1);
      if (due <= last_due) due = last_due + 1;
      last_due = due;
      pq_addr.push_back(mreq_addr); pq_ep.push_back(mreq_epoch); pq_due.push_back(due);
      exp_pc = mreq_addr + 32'd4;
    end
    // R3 / R6: monitor pops the scoreboard
    ofire = out_valid && out_ready;
    if (ofire) begin
      if (exp_q.size() == 0) begin
        check(0, "R3", "delivery with empty scoreboard", out_pc, 32'hFFFF_FFFF);
      end else begin
        e = exp_q.pop_front();
        check(out_pc == e, "R3", "out_pc order", out_pc, e);
        check(out_instr == word_at(e), "R3", "out_instr", out_instr, word_at(e));
      end
      if (await_first) begin
        check(out_pc == first_target, "R6", "first pc after redirect", out_pc, first_target);
        await_first = 0;
      end
    end
    prev_hold  = out_valid && !out_ready && !rd;
    prev_pc    = out_pc;
    prev_instr = out_instr;
    since_redir++;
    if (rd) begin
      exp_q.delete();
      exp_pc       = ra & ~32'd3;
      first_target = exp_pc;
      await_first  = 1;
      ep           = ep + 2'd1;
      since_redir  = 0;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(mreq_valid && mreq_addr == 0, "R1", "first request addr", mreq_addr, 0);
    check(mreq_epoch == 0, "R1", "first request epoch", 32'(mreq_epoch), 0);
    check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);

    // R8: fill with decode stalled, then drain without gaps
    for (int i = 0; i < 30; i++) step(0, 0, 100, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 100, 100, 1, 1);

    // R5, R6: misaligned redirect with fetches in flight
    for (int i = 0; i < 5; i++) step(0, 0, 100, 50, 4, 0);
    step(1, 32'h0000_1003, 100, 50, 4, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 100, 50, 4, 0);

    // randomised phases: ready rates, latency, redirects
    for (int p = 0; p < 6; p++) begin
      int rdy  = (p % 3 == 0) ? 100 : (p % 3 == 1) ? 60 : 30;
      int ordy = (p < 3) ? 70 : 25;
      int lat  = 1 + (p % 4);
      for (int i = 0; i < 600; i++) begin
        bit rd = (since_redir >= 6) && ($urandom_range(99) < 3);
        logic [31:0] tgt = $urandom;
        step(rd, tgt, rdy, ordy, lat, 0);
      end
    end
    // drain
    for (int i = 0; i < 40; i++) step(0, 0, 100, 100, 2, 0);
    done = 1;
    finish_run();
  end
endmodule